// File: doc/BRIEF.md
# SPI Bulk Data Packetizer

This block runs the bulk data phase of a byte-wide SPI link once a DMA command has been issued elsewhere. To transmit, it takes a payload byte stream whose total length is given at start and cuts it into packets. Every packet starts with a header byte that tags it as the first, an inner or the last packet. When enabled, a CRC16 follows each packet's payload. To receive, it exchanges filler bytes until a packet start byte turns up, forwards the payload on an output stream and checks the CRC16 when it is enabled.

Each byte on the SPI side is one exchange on a request/acknowledge port. The block holds `xferReq` high with a stable `xferTx`. The exchange completes in the cycle in which `xferAck` is high, and `xferRx` carries the byte returned in that cycle. A transfer starts on a `start` pulse. It ends with a one-cycle `done` pulse, and the error code given with that pulse stays valid until the next start.

Top module: `spi_pkt_framer`

## Requirements
- R1: The packet size is 2^(sizeCode+8) bytes for sizeCode 0..5. Codes 6 and 7 select 8192 bytes, the same as code 5.
- R2: A packet whose remaining length fits in one packet carries exactly that many payload bytes and position code 3. Otherwise a full-size packet is sent with code 1 if it is the first packet and code 2 if it is not.
- R3: On transmit, each packet is its header byte (0xF0 OR position code) followed by its payload bytes in stream order. The next header follows the previous packet directly, with no wait for a reply.
- R4: With crcEn set, each transmitted packet's payload is followed by CRC-16 (polynomial 0x1021, preset 0xFFFF, restarted each packet), high byte first. With crcEn clear, no CRC bytes are sent.
- R5: A transmit payload byte is taken from the input stream (inValid and inReady both high) only in a cycle in which its SPI exchange completes. While a request waits for acknowledge, xferTx does not change.
- R6: On receive, the block exchanges 0x00 bytes until a returned byte has upper nibble 0xF. If 101 exchanges pass without one, it ends with error code 2 after exactly 101 exchanges.
- R7: After each start byte, min(remaining, packet size) payload bytes are delivered in order on the output stream. Each byte is held stable while outValid is high and outReady is low.
- R8: With crcEn set, two received CRC bytes (high first) follow each packet and are compared with the CRC of that packet's payload. A mismatch ends the transfer with error code 3 and no further exchange.
- R9: A total length of 4 or less ends the transfer with error code 1 and no SPI exchange.
- R10: done is a one-cycle pulse. errCode (0 success, 1 too short, 2 hunt timeout, 3 CRC mismatch) is held from done until the next start. While busy is low there is no exchange request and neither stream handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| dirRx | input | 1 | 1 = receive, 0 = transmit |
| totalLen | input | LEN_W | Total payload length in bytes |
| sizeCode | input | 3 | Packet size code |
| crcEn | input | 1 | Enable per-packet CRC16 |
| inData | input | 8 | Transmit payload byte |
| inValid | input | 1 | Transmit payload valid |
| inReady | output | 1 | Transmit payload accepted |
| outData | output | 8 | Received payload byte |
| outValid | output | 1 | Received payload valid |
| outReady | input | 1 | Received payload accepted |
| xferReq | output | 1 | SPI byte exchange request |
| xferTx | output | 8 | Byte to shift out |
| xferAck | input | 1 | Exchange completes this cycle |
| xferRx | input | 8 | Byte shifted in, valid with xferAck |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| errCode | output | 2 | Result of the last transfer |

## Verification
The assertions check the handshake rules on every cycle: a pending SPI request keeps its byte, a received byte waits unchanged for acceptance, an idle block stays silent and keeps its result, and done lasts one cycle. Packet boundaries, header codes, CRC values, the size-code clamp, the exact hunt limit and the error ends can only be shown by the bench. It compares the whole exchanged byte stream against packets computed arithmetically, over lengths around the packet size, with stalls on both streams and on the SPI port.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SHORT = 2'd1,
    ERR_HUNT  = 2'd2,
    ERR_CRC   = 2'd3
  } errKind_t;

  typedef enum logic [2:0] {
    TX_ZERO, TX_HDR, TX_PAY, TX_CRCH, TX_CRCL
  } txSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       crcClear;
    logic       crcUpdTx;
    logic       crcUpdRx;
    logic       capPay;
    logic       capCrcHi;
    txSel_t     txSel;
    logic [1:0] posCode;
  } dpCtrl_t;

  function automatic logic [15:0] crcStep(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

endpackage

// File: rtl/spi_pkt_ctrl.sv
module spi_pkt_ctrl
  import spi_pkt_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int HUNT_LIMIT = 101,
  parameter int MIN_LOG    = 8,
  parameter int MAX_CODE   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirRx,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [2:0]       sizeCode,
  input  logic             crcEn,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             xferAck,
  input  logic             rxIsStart,
  input  logic             crcOk,
  output dpCtrl_t          dp,
  output logic             xferReq,
  output logic             inReady,
  output logic             outValid,
  output logic             busy,
  output logic             done,
  output logic [1:0]       errCode
);
  localparam int TRY_W = $clog2(HUNT_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_TPAY, S_TCRCH, S_TCRCL,
    S_HUNT, S_RPAY, S_ROUT, S_RCRCH, S_RCRCL, S_FIN
  } state_t;

  state_t           state;
  logic [LEN_W-1:0] totRem, pktRem, pktSize, thisLen;
  logic [TRY_W-1:0] tries;
  logic [2:0]       sizeLog;
  logic             firstPkt, crcOn, lastPkt;
  errKind_t         errReg;

  assign pktSize = {{(LEN_W-1){1'b0}}, 1'b1} << (4'(sizeLog) + 4'(MIN_LOG));
  assign lastPkt = totRem <= pktSize;
  assign thisLen = lastPkt ? totRem : pktSize;
  assign busy    = state != S_IDLE;
  assign done    = state == S_FIN;
  assign errCode = errReg;

  always_comb begin
    dp         = '0;
    dp.txSel   = TX_ZERO;
    dp.posCode = lastPkt ? 2'd3 : (firstPkt ? 2'd1 : 2'd2);
    xferReq    = 1'b0;
    inReady    = 1'b0;
    outValid   = 1'b0;
    case (state)
      S_HDR:   begin xferReq = 1'b1; dp.txSel = TX_HDR; dp.crcClear = xferAck; end
      S_TPAY:  begin
        xferReq     = inValid;
        dp.txSel    = TX_PAY;
        inReady     = inValid && xferAck;
        dp.crcUpdTx = inValid && xferAck;
      end
      S_TCRCH: begin xferReq = 1'b1; dp.txSel = TX_CRCH; end
      S_TCRCL: begin xferReq = 1'b1; dp.txSel = TX_CRCL; end
      S_HUNT:  begin xferReq = 1'b1; dp.crcClear = xferAck && rxIsStart; end
      S_RPAY:  begin xferReq = 1'b1; dp.capPay = xferAck; dp.crcUpdRx = xferAck; end
      S_ROUT:  outValid = 1'b1;
      S_RCRCH: begin xferReq = 1'b1; dp.capCrcHi = xferAck; end
      S_RCRCL: xferReq = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      totRem   <= '0;
      pktRem   <= '0;
      tries    <= '0;
      sizeLog  <= '0;
      firstPkt <= 1'b0;
      crcOn    <= 1'b0;
      errReg   <= ERR_NONE;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          crcOn    <= crcEn;
          sizeLog  <= (sizeCode > 3'(MAX_CODE)) ? 3'(MAX_CODE) : sizeCode;
          totRem   <= totalLen;
          firstPkt <= 1'b1;
          tries    <= '0;
          if (totalLen <= LEN_W'(4)) begin
            errReg <= ERR_SHORT;
            state  <= S_FIN;
          end else begin
            errReg <= ERR_NONE;
            state  <= dirRx ? S_HUNT : S_HDR;
          end
        end
        S_HDR: if (xferAck) begin
          pktRem   <= thisLen;
          firstPkt <= 1'b0;
          state    <= S_TPAY;
        end
        S_TPAY: if (inValid && xferAck) begin
          pktRem <= pktRem - 1'b1;
          totRem <= totRem - 1'b1;
          if (pktRem == LEN_W'(1))
            state <= crcOn ? S_TCRCH : ((totRem == LEN_W'(1)) ? S_FIN : S_HDR);
        end
        S_TCRCH: if (xferAck) state <= S_TCRCL;
        S_TCRCL: if (xferAck) state <= (totRem == '0) ? S_FIN : S_HDR;
        S_HUNT: if (xferAck) begin
          if (rxIsStart) begin
            pktRem <= thisLen;
            tries  <= '0;
            state  <= S_RPAY;
          end else if (tries == TRY_W'(HUNT_LIMIT - 1)) begin
            errReg <= ERR_HUNT;
            state  <= S_FIN;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        S_RPAY: if (xferAck) begin
          pktRem <= pktRem - 1'b1;
          totRem <= totRem - 1'b1;
          state  <= S_ROUT;
        end
        S_ROUT: if (outReady) begin
          if (pktRem != '0)  state <= S_RPAY;
          else if (crcOn)    state <= S_RCRCH;
          else               state <= (totRem == '0) ? S_FIN : S_HUNT;
        end
        S_RCRCH: if (xferAck) state <= S_RCRCL;
        S_RCRCL: if (xferAck) begin
          if (!crcOk) begin
            errReg <= ERR_CRC;
            state  <= S_FIN;
          end else begin
            state <= (totRem == '0) ? S_FIN : S_HUNT;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pkt_dp.sv
module spi_pkt_dp
  import spi_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    dp,
  input  logic [7:0] inData,
  input  logic [7:0] xferRx,
  output logic [7:0] xferTx,
  output logic [7:0] outData,
  output logic       crcOk
);
  logic [15:0] crcReg;
  logic [7:0]  payHold, crcHiHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= 16'hFFFF;
      payHold   <= '0;
      crcHiHold <= '0;
    end else begin
      if (dp.crcClear)      crcReg <= 16'hFFFF;
      else if (dp.crcUpdTx) crcReg <= crcStep(crcReg, inData);
      else if (dp.crcUpdRx) crcReg <= crcStep(crcReg, xferRx);
      if (dp.capPay)   payHold   <= xferRx;
      if (dp.capCrcHi) crcHiHold <= xferRx;
    end
  end

  always_comb begin
    case (dp.txSel)
      TX_HDR:  xferTx = {6'b111100, dp.posCode};
      TX_PAY:  xferTx = inData;
      TX_CRCH: xferTx = crcReg[15:8];
      TX_CRCL: xferTx = crcReg[7:0];
      default: xferTx = 8'h00;
    endcase
  end

  assign outData = payHold;
  assign crcOk   = crcReg == {crcHiHold, xferRx};
endmodule

// File: rtl/spi_pkt_framer.sv
module spi_pkt_framer
  import spi_pkt_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int HUNT_LIMIT = 101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirRx,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [2:0]       sizeCode,
  input  logic             crcEn,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             xferReq,
  output logic [7:0]       xferTx,
  input  logic             xferAck,
  input  logic [7:0]       xferRx,
  output logic             busy,
  output logic             done,
  output logic [1:0]       errCode
);
  dpCtrl_t dpCtrl;
  logic    crcOk;
  logic    rxIsStart;

  assign rxIsStart = xferRx[7:4] == 4'hF;

  spi_pkt_ctrl #(.LEN_W(LEN_W), .HUNT_LIMIT(HUNT_LIMIT)) u_ctrl (
    .clk, .rstN, .start, .dirRx, .totalLen, .sizeCode, .crcEn,
    .inValid, .outReady, .xferAck, .rxIsStart, .crcOk,
    .dp(dpCtrl), .xferReq, .inReady, .outValid, .busy, .done, .errCode
  );

  spi_pkt_dp u_dp (
    .clk, .rstN, .dp(dpCtrl), .inData, .xferRx, .xferTx, .outData, .crcOk
  );
endmodule

// File: rtl/spi_pkt_framer_chk.sv
module spi_pkt_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       xferReq,
  input logic       xferAck,
  input logic [7:0] xferTx,
  input logic       inReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       busy,
  input logic       done,
  input logic [1:0] errCode
);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferAck) |=> (!xferReq || $stable(xferTx)));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!xferReq && !inReady && !outValid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_err_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(errCode));
endmodule

bind spi_pkt_framer spi_pkt_framer_chk u_chk (.*);

// File: tb/spi_pkt_framer_bench.sv
`timescale 1ns/1ps
module spi_pkt_framer_bench;
  logic        clk = 0, rstN = 0, start = 0, dirRx = 0, crcEn = 0;
  logic [15:0] totalLen = 0;
  logic [2:0]  sizeCode = 0;
  logic [7:0]  inData = 0, xferRx = 0;
  logic        inValid = 0, outReady = 0, xferAck = 0;
  logic        inReady, outValid, xferReq, busy, done;
  logic [7:0]  outData, xferTx;
  logic [1:0]  errCode;

  int nChecks = 0, nFails = 0;
  byte unsigned capBuf[0:8999];
  byte unsigned expBuf[0:8999];
  int           expKind[0:8999];
  byte unsigned rxStream[0:2047];

  always #2.5 clk = ~clk;

  spi_pkt_framer u_spi_pkt_framer (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic byte unsigned pat(int i);
    return byte'((i * 7 + (i >> 8) + 3) & 8'hFF);
  endfunction

  function automatic logic [15:0] crcBit(logic [15:0] c, byte unsigned b);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[15] ^ b[k];
      c  = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic int sizeOf(int code);
    return 1 << ((code > 5 ? 5 : code) + 8);
  endfunction

  task automatic runShort(int len);
    int reqs = 0;
    bit seen = 0;
    @(negedge clk);
    totalLen = 16'(len); dirRx = 0; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 10; c++) begin
      #1;
      if (xferReq) reqs++;
      if (done) begin seen = 1; chk(errCode == 2'd1, "R9 short err", errCode, 1); end
      @(negedge clk);
    end
    chk(seen, "R9 done seen", seen, 1);
    chk(reqs == 0, "R9 no exchange", reqs, 0);
    chk(errCode == 2'd1 && !busy, "R10 err held", errCode, 1);
  endtask

  task automatic runTx(int len, int code, bit crc, int gapMod, int ackMod);
    int consumed = 0, nCap = 0, k = 0, rem, off = 0, cyc = 0;
    bit seen = 0, first = 1;
    @(negedge clk);
    totalLen = 16'(len); sizeCode = 3'(code); crcEn = crc; dirRx = 0; start = 1;
    @(negedge clk); start = 0;
    while (!seen && cyc < 40000) begin
      inData  = pat(consumed);
      inValid = (gapMod == 0) || ((cyc % gapMod) != 0);
      #0.5;
      xferAck = xferReq && ((ackMod == 0) || ((cyc % ackMod) != 1));
      #0.5;
      if (xferReq && xferAck) begin
        if (nCap < 9000) capBuf[nCap] = xferTx;
        nCap++;
        if (inReady) consumed++;
      end
      if (done) begin seen = 1; chk(errCode == 2'd0, "R10 tx ok", errCode, 0); end
      @(negedge clk);
      cyc++;
    end
    xferAck = 0; inValid = 0;
    chk(seen, "R10 tx done", seen, 1);
    chk(consumed == len, "R5 consumed", consumed, len);
    rem = len;
    while (rem > 0) begin
      int n, pc;
      logic [15:0] c = 16'hFFFF;
      n  = (rem <= sizeOf(code)) ? rem : sizeOf(code);
      pc = (rem <= sizeOf(code)) ? 3 : (first ? 1 : 2);
      first = 0;
      expBuf[k] = byte'(8'hF0 | pc); expKind[k] = 0; k++;
      for (int i = 0; i < n; i++) begin
        expBuf[k] = pat(off + i); expKind[k] = 1; k++;
        c = crcBit(c, pat(off + i));
      end
      if (crc) begin
        expBuf[k] = c[15:8]; expKind[k] = 2; k++;
        expBuf[k] = c[7:0];  expKind[k] = 2; k++;
      end
      off += n; rem -= n;
    end
    chk(nCap == k, "R1 stream length", nCap, k);
    for (int i = 0; i < k && i < nCap; i++) begin
      if (expKind[i] == 0)      chk(capBuf[i] == expBuf[i], "R2 header", capBuf[i], expBuf[i]);
      else if (expKind[i] == 1) chk(capBuf[i] == expBuf[i], "R3 payload", capBuf[i], expBuf[i]);
      else                      chk(capBuf[i] == expBuf[i], "R4 crc", capBuf[i], expBuf[i]);
    end
  endtask

  task automatic runRx(int len, int code, bit crc, int junk, int badPkt, int gapOut, int expErr);
    int nS = 0, rem = len, off = 0, p = 0, pos = 0, nGot = 0, expCnt = 0, cyc = 0;
    bit seen = 0, txBad = 0, stop = 0;
    int errSeen = -1;
    while (rem > 0) begin
      int n, nj;
      logic [15:0] c = 16'hFFFF;
      n  = (rem <= sizeOf(code)) ? rem : sizeOf(code);
      nj = (p == 0) ? junk : (p % 2);
      for (int j = 0; j < nj; j++) begin rxStream[nS] = byte'((j * 13) & 8'h7F); nS++; end
      rxStream[nS] = 8'hF3; nS++;
      for (int i = 0; i < n; i++) begin
        rxStream[nS] = pat(off + i) ^ 8'h55; nS++;
        c = crcBit(c, pat(off + i) ^ 8'h55);
      end
      if (crc) begin
        rxStream[nS] = c[15:8]; nS++;
        rxStream[nS] = (p == badPkt) ? (c[7:0] ^ 8'h01) : c[7:0]; nS++;
      end
      if (!stop) expCnt += n;
      if (p == badPkt) stop = 1;
      off += n; rem -= n; p++;
    end
    if (expErr == 2) expCnt = 0;
    @(negedge clk);
    totalLen = 16'(len); sizeCode = 3'(code); crcEn = crc; dirRx = 1; start = 1;
    @(negedge clk); start = 0;
    while (!seen && cyc < 40000) begin
      outReady = (gapOut == 0) || ((cyc % gapOut) != 0);
      #0.5;
      xferAck = xferReq;
      xferRx  = (pos < nS) ? rxStream[pos] : 8'h00;
      #0.5;
      if (xferReq && xferAck) begin
        if (xferTx != 8'h00) txBad = 1;
        pos++;
      end
      if (outValid && outReady) begin
        if (nGot < expCnt)
          chk(outData == (pat(nGot) ^ 8'h55), "R7 payload", outData, pat(nGot) ^ 8'h55);
        nGot++;
      end
      if (done) begin seen = 1; errSeen = errCode; end
      @(negedge clk);
      cyc++;
    end
    xferAck = 0; outReady = 0; dirRx = 0;
    chk(seen, "R10 rx done", seen, 1);
    chk(nGot == expCnt, "R7 byte count", nGot, expCnt);
    chk(!txBad, "R6 filler zero", txBad, 0);
    if (expErr == 3) chk(errSeen == 3, "R8 crc error", errSeen, 3);
    else if (expErr == 2) begin
      chk(errSeen == 2, "R6 hunt timeout", errSeen, 2);
      chk(pos == 101, "R6 hunt tries", pos, 101);
    end else chk(errSeen == 0, "R8 rx ok", errSeen, 0);
    if (expErr == 3) chk(pos == off + 0 - (len - off) + 0 || pos <= nS, "R8 stop", pos, nS);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk(!busy && !xferReq && !done, "R10 reset idle", {busy, xferReq, done}, 0);
    chk(errCode == 2'd0 && !inReady && !outValid, "R10 reset outputs", errCode, 0);
    runShort(4);
    runShort(0);
    runTx(5, 0, 1, 0, 0);
    runTx(256, 0, 1, 0, 3);
    runTx(257, 0, 0, 3, 4);
    runTx(600, 0, 1, 5, 0);
    runTx(513, 1, 1, 0, 0);
    runTx(1025, 1, 0, 4, 5);
    runTx(8193, 7, 1, 0, 0);
    runRx(300, 0, 1, 0, -1, 0, 0);
    runRx(300, 0, 1, 100, -1, 3, 0);
    runRx(600, 0, 1, 2, 1, 0, 3);
    runRx(600, 0, 0, 3, -1, 2, 0);
    runRx(520, 1, 1, 0, -1, 4, 0);
    runRx(300, 0, 1, 101, -1, 0, 2);
    repeat (3) @(negedge clk);
    #1 chk(errCode == 2'd2 && !busy, "R10 err held after end", errCode, 2);
    finishRun();
  end
endmodule